// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block resolves the jump class of a 64-bit packet-filter virtual machine. Each cycle in which `in_valid` is high it takes an 8-bit opcode, the two register operands, a 32-bit immediate, a signed 16-bit displacement and the current program counter. It then decides whether control moves, and one clock later it presents the next program counter together with a taken flag. It also decodes the function-call and program-return opcodes and raises a one-cycle strobe for each. It does not resolve call targets or keep a return stack: the PC is held for those and the surrounding core acts on the strobe. Opcodes that do not belong to the jump classes, or that are invalid within them, raise an illegal flag.

The opcode splits into three fields. Bits 7:4 carry the operation, bit 3 picks the right-hand operand, and bits 2:0 give the class. Class 5 compares full 64-bit values. Class 6 compares only the low halves. The PC counts 8-byte instruction slots, so a fall-through adds one. A taken branch adds one plus the displacement, and the sum wraps at the PC width.

Top module: `br_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared on that edge: `out_valid`, `taken`, `call_stb`, `exit_stb`, `illegal` go to 0 and `next_pc` goes to 0.
- R2: The results for a request sampled with `in_valid` high appear on the following cycle with `out_valid` high. After an edge where `in_valid` was low, `out_valid`, `taken`, `call_stb`, `exit_stb` and `illegal` are all 0 and `next_pc` keeps its previous value. Requests may arrive on consecutive cycles.
- R3: Class value 5 (opcode bits 2:0) compares all 64 bits of both operands. Class value 6 compares only bits 31:0 of each operand, with bit 31 acting as the sign bit for signed tests.
- R4: Opcode bit 3 set selects `src_val` as the right-hand operand. Bit 3 clear selects `imm`, sign-extended to 64 bits in class 5. The left-hand operand is always `dst_val`.
- R5: Unsigned tests, by operation (opcode bits 7:4): 0x2 taken if left > right, 0x3 if left >= right, 0xA if left < right, 0xB if left <= right.
- R6: Signed two's-complement tests: 0x6 taken if left > right, 0x7 if left >= right, 0xC if left < right, 0xD if left <= right.
- R7: Operation 0x1 is taken on equality and 0x5 on inequality. Operation 0x4 is taken when the bitwise AND of the operands is nonzero.
- R8: For a valid request that is not a call or return, `next_pc` is `pc + 1 + sign_extend(offset)` when taken and `pc + 1` otherwise, modulo 2^32.
- R9: Operation 0x0 in class 5 is taken regardless of the operand values.
- R10: Operation 0x8 (call) in class 5 or 6 pulses `call_stb`. Operation 0x9 (return) in class 5 pulses `exit_stb`. For both, `taken` is 0 and `next_pc` equals the request's `pc`.
- R11: `illegal` is raised, with `taken`, `call_stb` and `exit_stb` at 0 and `next_pc = pc + 1`, for any of these: a class other than 5 or 6; operation 0xE or 0xF; operation 0x0 or 0x9 in class 6.
- R12: At most one of `taken`, `call_stb`, `exit_stb`, `illegal` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 8 | Operation [7:4], operand select [3], class [2:0] |
| dst_val | input | 64 | Left-hand register value |
| src_val | input | 64 | Right-hand register value |
| imm | input | 32 | Immediate right-hand operand |
| offset | input | 16 | Signed branch displacement in slots |
| pc | input | 32 | Current program counter (slot index) |
| out_valid | output | 1 | Result present |
| next_pc | output | 32 | Resolved next program counter |
| taken | output | 1 | Branch taken |
| call_stb | output | 1 | One-cycle call indication |
| exit_stb | output | 1 | One-cycle return indication |
| illegal | output | 1 | Invalid opcode for this unit |

## Verification
The illegal decode can meet a comparison that would otherwise succeed in the same request. The unconditional jump and the return opcode are sent in the 32-bit class, and an equality opcode is sent in a foreign class with equal operands. Each should report illegal only, with the fall-through PC. The narrow and wide comparators can also disagree on one operand pair. Pairs whose upper halves differ while the low halves match, or whose bit 31 flips the sign only in 32-bit view, are sent under both classes, and the flag and PC are judged against values worked out from the requirements.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int unsigned OPC_W = 8;
    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;

    typedef enum logic [3:0] {
        OP_JA    = 4'h0,
        OP_JEQ   = 4'h1,
        OP_JGT   = 4'h2,
        OP_JGE   = 4'h3,
        OP_JSET  = 4'h4,
        OP_JNE   = 4'h5,
        OP_JSGT  = 4'h6,
        OP_JSGE  = 4'h7,
        OP_CALL  = 4'h8,
        OP_EXIT  = 4'h9,
        OP_JLT   = 4'hA,
        OP_JLE   = 4'hB,
        OP_JSLT  = 4'hC,
        OP_JSLE  = 4'hD,
        OP_RSV_E = 4'hE,
        OP_RSV_F = 4'hF
    } br_op_e;

    typedef struct packed {
        br_op_e op;
        logic   use_reg;
        logic   narrow;
        logic   illegal;
    } br_dec_t;

    typedef struct packed {
        logic taken;
        logic call;
        logic exit;
        logic illegal;
    } br_res_t;

    function automatic br_dec_t br_decode(input logic [OPC_W-1:0] opc);
        br_dec_t d;
        logic    wide;
        logic    narrow;
        wide      = (opc[2:0] == CLS_WIDE);
        narrow    = (opc[2:0] == CLS_NARROW);
        d.op      = br_op_e'(opc[7:4]);
        d.use_reg = opc[3];
        d.narrow  = narrow;
        d.illegal = !(wide || narrow)
                  || (d.op == OP_RSV_E) || (d.op == OP_RSV_F)
                  || (narrow && ((d.op == OP_JA) || (d.op == OP_EXIT)));
        return d;
    endfunction

endpackage

// File: rtl/br_operand.sv
module br_operand #(
    parameter int unsigned DW = 64,
    parameter int unsigned IW = 32
) (
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [IW-1:0] imm_i,
    input  logic          use_reg_i,
    input  logic          narrow_i,
    output logic [DW-1:0] lhs_o,
    output logic [DW-1:0] rhs_o
);
    localparam int unsigned HW = DW / 2;

    logic [DW-1:0] rhs_raw;

    // Sign-extending the low halves keeps equality, AND-nonzero,
    // signed and unsigned order identical to a true half-width compare.
    always_comb begin
        rhs_raw = use_reg_i ? src_i : {{(DW-IW){imm_i[IW-1]}}, imm_i};
        if (narrow_i) begin
            lhs_o = {{(DW-HW){dst_i[HW-1]}}, dst_i[HW-1:0]};
            rhs_o = {{(DW-HW){rhs_raw[HW-1]}}, rhs_raw[HW-1:0]};
        end else begin
            lhs_o = dst_i;
            rhs_o = rhs_raw;
        end
    end
endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int unsigned DW = 64
) (
    input  logic [DW-1:0] lhs_i,
    input  logic [DW-1:0] rhs_i,
    input  br_dec_t       dec_i,
    output br_res_t       res_o
);
    logic eq, ult, slt, anyset, hit;

    always_comb begin
        eq     = (lhs_i == rhs_i);
        ult    = (lhs_i < rhs_i);
        slt    = ($signed(lhs_i) < $signed(rhs_i));
        anyset = |(lhs_i & rhs_i);
        unique case (dec_i.op)
            OP_JA:   hit = 1'b1;
            OP_JEQ:  hit = eq;
            OP_JNE:  hit = !eq;
            OP_JSET: hit = anyset;
            OP_JGT:  hit = !ult && !eq;
            OP_JGE:  hit = !ult;
            OP_JLT:  hit = ult;
            OP_JLE:  hit = ult || eq;
            OP_JSGT: hit = !slt && !eq;
            OP_JSGE: hit = !slt;
            OP_JSLT: hit = slt;
            OP_JSLE: hit = slt || eq;
            default: hit = 1'b0;
        endcase
        res_o.illegal = dec_i.illegal;
        res_o.taken   = !dec_i.illegal && hit;
        res_o.call    = !dec_i.illegal && (dec_i.op == OP_CALL);
        res_o.exit    = !dec_i.illegal && (dec_i.op == OP_EXIT);
    end
endmodule

// File: rtl/br_pc_reg.sv
module br_pc_reg
    import br_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  br_res_t          res_i,
    output logic             out_valid_o,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             taken_o,
    output logic             call_o,
    output logic             exit_o,
    output logic             illegal_o
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] tgt_pc;
    logic [PC_W-1:0] pc_sel;

    always_comb begin
        seq_pc = pc_i + PC_W'(1);
        tgt_pc = seq_pc + {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
        if (res_i.call || res_i.exit) pc_sel = pc_i;
        else if (res_i.taken)         pc_sel = tgt_pc;
        else                          pc_sel = seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            next_pc_o   <= '0;
            taken_o     <= 1'b0;
            call_o      <= 1'b0;
            exit_o      <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            out_valid_o <= valid_i;
            taken_o     <= valid_i && res_i.taken;
            call_o      <= valid_i && res_i.call;
            exit_o      <= valid_i && res_i.exit;
            illegal_o   <= valid_i && res_i.illegal;
            if (valid_i) next_pc_o <= pc_sel;
        end
    end

    a_r12_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({taken_o, call_o, exit_o, illegal_o}));

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid_o |-> !(taken_o || call_o || exit_o || illegal_o));

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> out_valid_o);

    a_r2_hold_pc: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(next_pc_o));

    a_r8_fallthrough: assert property (@(posedge clk) disable iff (rst)
        valid_i && !res_i.taken && !res_i.call && !res_i.exit
        |=> next_pc_o == $past(pc_i) + PC_W'(1));

    a_r10_pc_held: assert property (@(posedge clk) disable iff (rst)
        valid_i && (res_i.call || res_i.exit) |=> next_pc_o == $past(pc_i));
endmodule

// File: rtl/br_unit.sv
module br_unit
    import br_pkg::*;
#(
    parameter int unsigned DW    = 64,
    parameter int unsigned IW    = 32,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       opcode,
    input  logic [DW-1:0]    dst_val,
    input  logic [DW-1:0]    src_val,
    input  logic [IW-1:0]    imm,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  pc,
    output logic             out_valid,
    output logic [PC_W-1:0]  next_pc,
    output logic             taken,
    output logic             call_stb,
    output logic             exit_stb,
    output logic             illegal
);
    br_dec_t       dec;
    br_res_t       res;
    logic [DW-1:0] lhs;
    logic [DW-1:0] rhs;

    assign dec = br_decode(opcode);

    br_operand #(.DW(DW), .IW(IW)) u_operand (
        .dst_i     (dst_val),
        .src_i     (src_val),
        .imm_i     (imm),
        .use_reg_i (dec.use_reg),
        .narrow_i  (dec.narrow),
        .lhs_o     (lhs),
        .rhs_o     (rhs)
    );

    br_cond #(.DW(DW)) u_cond (
        .lhs_i (lhs),
        .rhs_i (rhs),
        .dec_i (dec),
        .res_o (res)
    );

    br_pc_reg #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (in_valid),
        .pc_i        (pc),
        .off_i       (offset),
        .res_i       (res),
        .out_valid_o (out_valid),
        .next_pc_o   (next_pc),
        .taken_o     (taken),
        .call_o      (call_stb),
        .exit_o      (exit_stb),
        .illegal_o   (illegal)
    );

    a_r9_ja_taken: assert property (@(posedge clk) disable iff (rst)
        in_valid && (opcode == 8'h05) |=> taken);

    a_r11_reserved_op: assert property (@(posedge clk) disable iff (rst)
        in_valid && (opcode[7:4] >= 4'hE) |=> illegal && !taken);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid && !taken && !call_stb && !exit_stb && !illegal);
endmodule

// File: tb/br_unit_bench.sv
`timescale 1ns/1ps
module br_unit_bench;

    typedef struct packed {
        logic [7:0]  opc;
        logic [63:0] dst;
        logic [63:0] src;
        logic [31:0] imm;
        logic [15:0] off;
        logic [31:0] pc;
        logic [3:0]  exp;   // {taken, call, exit, illegal}
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 35;

    localparam vec_t VECS [NV] = '{
        '{8'h1D, 64'd5, 64'd5, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd7},  // R7 eq
        '{8'h1D, 64'd5, 64'd6, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd7},  // R7
        '{8'h5D, 64'd5, 64'd6, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd7},  // R7 ne
        '{8'h5D, 64'd5, 64'd5, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd7},  // R7
        '{8'h4D, 64'hF0, 64'h0F, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd7}, // R7 set
        '{8'h4D, 64'h10, 64'h30, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd7}, // R7
        '{8'h2D, M1, 64'd1, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd5},     // R5
        '{8'h6D, M1, 64'd1, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd6},     // R6
        '{8'hCD, M1, 64'd1, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd6},     // R6
        '{8'hAD, 64'd3, 64'd3, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd5},  // R5
        '{8'hBD, 64'd3, 64'd3, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd5},  // R5
        '{8'h3D, 64'd2, 64'd3, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd5},  // R5
        '{8'h7D, M1, M1, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd6},        // R6
        '{8'hDD, 64'd1, M1, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd6},     // R6
        '{8'h1E, 64'h1_0000_0005, 64'h2_0000_0005, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd3}, // R3
        '{8'h1D, 64'h1_0000_0005, 64'h2_0000_0005, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd3}, // R3
        '{8'h6E, 64'h8000_0000, 64'd1, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd3},  // R3
        '{8'h6D, 64'h8000_0000, 64'd1, 32'd0, 16'd10, 32'd100, 4'b1000, 8'd3},  // R3
        '{8'h15, M1, 64'd0, 32'hFFFF_FFFF, 16'd10, 32'd100, 4'b1000, 8'd4},     // R4
        '{8'h16, 64'hFFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd10, 32'd100, 4'b1000, 8'd4}, // R4
        '{8'h15, 64'hFFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 16'd10, 32'd100, 4'b0000, 8'd4}, // R4
        '{8'h15, 64'd7, 64'd7, 32'd8, 16'd10, 32'd100, 4'b0000, 8'd4},  // R4
        '{8'h1D, 64'd7, 64'd7, 32'd8, 16'd10, 32'd100, 4'b1000, 8'd4},  // R4
        '{8'h05, 64'd1, 64'd2, 32'd0, 16'hFFFD, 32'd100, 4'b1000, 8'd9}, // R9
        '{8'h05, 64'd0, 64'd0, 32'd0, 16'hFFFB, 32'd0, 4'b1000, 8'd8},   // R8 wrap
        '{8'h2D, 64'd0, 64'd1, 32'd0, 16'd10, 32'hFFFF_FFFF, 4'b0000, 8'd8}, // R8
        '{8'h06, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0001, 8'd11}, // R11
        '{8'h95, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0010, 8'd10}, // R10
        '{8'h96, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0001, 8'd11}, // R11
        '{8'h85, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0100, 8'd10}, // R10
        '{8'h86, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0100, 8'd10}, // R10
        '{8'hE5, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0001, 8'd11}, // R11
        '{8'hFD, 64'd0, 64'd0, 32'd0, 16'd10, 32'd100, 4'b0001, 8'd11}, // R11
        '{8'h1C, 64'd5, 64'd5, 32'd0, 16'd10, 32'd100, 4'b0001, 8'd11}, // R11
        '{8'h4E, 64'h1_0000_0000, 64'h1_0000_0000, 32'd0, 16'd10, 32'd100, 4'b0000, 8'd3} // R3
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  opcode;
    logic [63:0] dst_val, src_val;
    logic [31:0] imm;
    logic [15:0] offset;
    logic [31:0] pc;
    logic        out_valid;
    logic [31:0] next_pc;
    logic        taken, call_stb, exit_stb, illegal;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    br_unit u_br_unit (
        .clk (clk), .rst (rst), .in_valid (in_valid), .opcode (opcode),
        .dst_val (dst_val), .src_val (src_val), .imm (imm), .offset (offset),
        .pc (pc), .out_valid (out_valid), .next_pc (next_pc), .taken (taken),
        .call_stb (call_stb), .exit_stb (exit_stb), .illegal (illegal)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        logic [31:0] exp_pc;
        rst = 1'b1; in_valid = 1'b0; opcode = '0; dst_val = '0; src_val = '0;
        imm = '0; offset = '0; pc = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 flags", 64'({taken, call_stb, exit_stb, illegal}), 64'd0);
        chk("R1 next_pc", 64'(next_pc), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        // R2: back-to-back requests walked from the table
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            opcode  = VECS[i].opc;  dst_val = VECS[i].dst; src_val = VECS[i].src;
            imm     = VECS[i].imm;  offset  = VECS[i].off; pc      = VECS[i].pc;
            @(negedge clk);
            if (VECS[i].exp[2] || VECS[i].exp[1]) exp_pc = VECS[i].pc;
            else if (VECS[i].exp[3]) exp_pc = VECS[i].pc + 32'd1 + {{16{VECS[i].off[15]}}, VECS[i].off};
            else exp_pc = VECS[i].pc + 32'd1;
            chk($sformatf("R%0d vec%0d flags", VECS[i].req, i),
                64'({taken, call_stb, exit_stb, illegal}), 64'(VECS[i].exp));
            chk($sformatf("R%0d vec%0d next_pc", VECS[i].req, i), 64'(next_pc), 64'(exp_pc));
            chk($sformatf("R2 vec%0d out_valid", i), 64'(out_valid), 64'd1);
        end
        // R2: idle cycle holds next_pc and drops every flag
        held = next_pc;
        in_valid = 1'b0;
        opcode = 8'h05;
        pc = 32'd500;
        @(negedge clk);
        chk("R2 idle out_valid", 64'(out_valid), 64'd0);
        chk("R2 idle flags", 64'({taken, call_stb, exit_stb, illegal}), 64'd0);
        chk("R2 idle next_pc", 64'(next_pc), 64'(held));
        // R10: call strobe lasts one cycle
        in_valid = 1'b1; opcode = 8'h85; pc = 32'd40;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 call pulse", 64'(call_stb), 64'd1);
        @(negedge clk);
        chk("R10 call dropped", 64'(call_stb), 64'd0);
        chk("R10 call pc", 64'(next_pc), 64'd40);
        // R1: reset mid-run clears a pending taken result
        in_valid = 1'b1; opcode = 8'h05; pc = 32'd7; offset = 16'd2;
        @(negedge clk);
        chk("R9 pre-reset taken", 64'(taken), 64'd1);
        chk("R8 pre-reset pc", 64'(next_pc), 64'd10);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset flags", 64'({out_valid, taken, call_stb, exit_stb, illegal}), 64'd0);
        chk("R1 mid reset pc", 64'(next_pc), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule